// File: doc/BRIEF.md
# Port-Indexed PHY Management Access Engine

This block lets software reach Ethernet PHY management registers by switch port number rather than by management bus and PHY address. Software first fills a port table that assigns each port one of four management buses and a 5-bit PHY address. It also sets, per bus, whether that bus carries Clause 22 or Clause 45 frames. It then issues a single read or write through a small set of access registers. The engine resolves the port, raises a request on the chosen bus's parallel request port, and waits for the response. It then posts the read data together with a failure flag.

The serial bit engine on each bus and the automatic PHY polling engine sit outside this block. The block holds the per-port polling-enable mask and drives it to the polling engine. Software clears that mask before it issues commands, so that polling does not contend with command accesses.

Each bus has a valid/ready request channel. The request fields are shared by all buses, because only one transaction is ever outstanding. The response channel has valid only and no back-pressure: the engine always accepts a response once the request on that bus has been accepted.

Top module: `port_mdio_engine`

## Requirements
- R1: After reset, every register reads zero except the timeout register, which reads 200. No request valid is high and the polling mask output is zero.
- R2: The register word addresses are: 0 bus clause mode, 1 polling mask, 2 command, 3 data, 4 Clause 45 address, 5 write port select, 6 timeout limit, 8 and 9 bus-select table, 10 to 14 PHY-address table. Port p takes its bus from bits 2*(p mod 16)+1:2*(p mod 16) of table word 8+p/16. It takes its PHY address from bits 5*(p mod 6)+4:5*(p mod 6) of word 10+p/6. A command is issued on that bus and carries that PHY address.
- R3: A read takes its target port from data bits 31:16. It is started by writing the command register with bit 0 (start/busy) set and bit 2 (write) clear. When it completes, data bits 15:0 hold the bus response and bits 31:16 still hold the port.
- R4: A write takes its target port from a one-hot mask in the port-select register. The request carries data bits 31:16 as write data, and the data register is left unchanged.
- R5: Command bit 1 selects Clause 45. For Clause 22, the request register field carries command bits 24:20 zero-extended, and the device field is zero. For Clause 45, the device field carries address bits 20:16 and the register field carries address bits 15:0.
- R6: Bit 16+b of the clause-mode register puts bus b into Clause 45. A start whose command bit 1 differs from the mode of the resolved bus completes at once: the failure flag (command bit 25) is set and no request is issued.
- R7: While busy, writes to the command, data, Clause 45 address and port-select registers are ignored, and a start has no effect.
- R8: A write start with a zero or multi-bit port mask, or a read start with a port number of 28 or more, completes at once with the failure flag set and no request.
- R9: If no response arrives within the programmed limit, the engine clears busy and sets the failure flag. The read data is left unchanged.
- R10: Only the resolved bus's request valid is raised. It stays high with stable fields until that bus asserts ready.
- R11: The polling mask output follows bits 27:0 of the polling register, and bits 31:28 read as zero.
- R12: A transaction that receives its response clears the failure flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| poll_en | output | 28 | Per-port polling enable |
| mb_req_valid | output | 4 | Request valid, one bit per bus |
| mb_req_ready | input | 4 | Request ready, one bit per bus |
| mb_c45 | output | 1 | Request uses Clause 45 frames |
| mb_write | output | 1 | Request is a write |
| mb_phy | output | 5 | PHY address |
| mb_dev | output | 5 | Clause 45 device address |
| mb_reg | output | 16 | Register number or Clause 45 register address |
| mb_wdata | output | 16 | Write data |
| mb_rsp_valid | input | 4 | Response valid, one bit per bus |
| mb_rsp_data | input | 64 | Response data, 16 bits per bus, bus 0 lowest |

## Verification
The assertions take for granted that a bus raises response valid only after it has accepted a request, and only on its own lane. They also assume a bus never asserts ready without a pending valid. The bench responder keeps within this. It waits a programmable number of cycles before raising ready on the requested bus, waits again before one response pulse, and a bus marked dead never answers at all. Random stimulus draws port maps, clause modes, targets and handshake latencies. The directed cases push the engine into immediate failures, timeouts and writes made while busy.

// File: rtl/mdio_eng_pkg.sv
package mdio_eng_pkg;
  localparam int BUS_FW    = 2;
  localparam int PHY_FW    = 5;
  localparam int SEL_PER_W = 16;
  localparam int PHY_PER_W = 6;

  localparam logic [3:0] A_GCTRL = 4'd0;
  localparam logic [3:0] A_POLL  = 4'd1;
  localparam logic [3:0] A_CMD   = 4'd2;
  localparam logic [3:0] A_DATA  = 4'd3;
  localparam logic [3:0] A_MMD   = 4'd4;
  localparam logic [3:0] A_PSEL  = 4'd5;
  localparam logic [3:0] A_LIMIT = 4'd6;
  localparam int         A_SEL0  = 8;
  localparam int         A_PHY0  = 10;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} seq_st_t;
endpackage

// File: rtl/mdio_port_map.sv
module mdio_port_map
  import mdio_eng_pkg::*;
#(
  parameter int NPORT = 28
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [3:0]               addr,
  input  logic [31:0]              wdata,
  input  logic [$clog2(NPORT)-1:0] port,
  output logic [BUS_FW-1:0]        lk_bus,
  output logic [PHY_FW-1:0]        lk_phy,
  output logic                     rd_hit,
  output logic [31:0]              rd_word
);
  localparam int PW        = $clog2(NPORT);
  localparam int TBL       = 1 << PW;
  localparam int SEL_WORDS = (NPORT + SEL_PER_W - 1) / SEL_PER_W;
  localparam int PHY_WORDS = (NPORT + PHY_PER_W - 1) / PHY_PER_W;

  logic [31:0] sel_w [SEL_WORDS];
  logic [31:0] phy_w [PHY_WORDS];
  logic [BUS_FW-1:0] bus_tab [TBL];
  logic [PHY_FW-1:0] phy_tab [TBL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SEL_WORDS; i++) sel_w[i] <= '0;
      for (int i = 0; i < PHY_WORDS; i++) phy_w[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < SEL_WORDS; i++)
        if (addr == 4'(A_SEL0 + i)) sel_w[i] <= wdata;
      for (int i = 0; i < PHY_WORDS; i++)
        if (addr == 4'(A_PHY0 + i)) phy_w[i] <= wdata;
    end
  end

  for (genvar p = 0; p < TBL; p++) begin : g_unpack
    if (p < NPORT) begin : g_live
      assign bus_tab[p] = sel_w[p / SEL_PER_W][(p % SEL_PER_W) * BUS_FW +: BUS_FW];
      assign phy_tab[p] = phy_w[p / PHY_PER_W][(p % PHY_PER_W) * PHY_FW +: PHY_FW];
    end else begin : g_pad
      assign bus_tab[p] = '0;
      assign phy_tab[p] = '0;
    end
  end

  assign lk_bus = bus_tab[port];
  assign lk_phy = phy_tab[port];

  always_comb begin
    rd_hit  = 1'b0;
    rd_word = '0;
    for (int i = 0; i < SEL_WORDS; i++)
      if (addr == 4'(A_SEL0 + i)) begin
        rd_hit  = 1'b1;
        rd_word = sel_w[i];
      end
    for (int i = 0; i < PHY_WORDS; i++)
      if (addr == 4'(A_PHY0 + i)) begin
        rd_hit  = 1'b1;
        rd_word = phy_w[i];
      end
  end
endmodule

// File: rtl/mdio_cmd_seq.sv
module mdio_cmd_seq
  import mdio_eng_pkg::*;
#(
  parameter int NBUS  = 4,
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 start_ok,
  input  logic [BUS_FW-1:0]    sel_bus,
  input  logic [PHY_FW-1:0]    sel_phy,
  input  logic [CNT_W-1:0]     limit,
  input  logic [NBUS-1:0]      mb_req_ready,
  input  logic [NBUS-1:0]      mb_rsp_valid,
  input  logic [NBUS*16-1:0]   mb_rsp_data,
  output logic [NBUS-1:0]      mb_req_valid,
  output logic [PHY_FW-1:0]    phy_q,
  output logic                 busy,
  output logic                 fail,
  output logic                 rsp_take,
  output logic [15:0]          rsp_word
);
  seq_st_t           state;
  logic [BUS_FW-1:0] bus_q;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  lim_q;
  logic              fail_q;

  assign busy     = (state != S_IDLE);
  assign fail     = fail_q;
  assign rsp_take = (state == S_WAIT) && mb_rsp_valid[bus_q];
  assign rsp_word = mb_rsp_data[{bus_q, 4'b0000} +: 16];

  for (genvar b = 0; b < NBUS; b++) begin : g_valid
    assign mb_req_valid[b] = (state == S_REQ) && (bus_q == BUS_FW'(b));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      bus_q  <= '0;
      phy_q  <= '0;
      cnt    <= '0;
      lim_q  <= '0;
      fail_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            if (start_ok) begin
              state <= S_REQ;
              bus_q <= sel_bus;
              phy_q <= sel_phy;
              lim_q <= limit;
              cnt   <= '0;
            end else begin
              fail_q <= 1'b1;
            end
          end
        end
        default: begin
          if (rsp_take) begin
            state  <= S_IDLE;
            fail_q <= 1'b0;
          end else if (cnt == lim_q) begin
            state  <= S_IDLE;
            fail_q <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
            if (state == S_REQ && mb_req_ready[bus_q]) state <= S_WAIT;
          end
        end
      endcase
    end
  end

  AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mb_req_valid)); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(mb_req_valid & ~mb_req_ready)) && cnt != lim_q) |=> $stable(mb_req_valid)); // R10
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= lim_q)); // R9
  AST_EXPIRY_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rsp_take && cnt == lim_q) |=> (fail && !busy)); // R9
  AST_OK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take |=> (!fail && !busy)); // R12
endmodule

// File: rtl/port_mdio_engine.sv
module port_mdio_engine
  import mdio_eng_pkg::*;
#(
  parameter int NPORT     = 28,
  parameter int NBUS      = 4,
  parameter int CNT_W     = 16,
  parameter int DEF_LIMIT = 200
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [3:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic [NPORT-1:0]    poll_en,
  output logic [NBUS-1:0]     mb_req_valid,
  input  logic [NBUS-1:0]     mb_req_ready,
  output logic                mb_c45,
  output logic                mb_write,
  output logic [4:0]          mb_phy,
  output logic [4:0]          mb_dev,
  output logic [15:0]         mb_reg,
  output logic [15:0]         mb_wdata,
  input  logic [NBUS-1:0]     mb_rsp_valid,
  input  logic [NBUS*16-1:0]  mb_rsp_data
);
  localparam int PW = $clog2(NPORT);

  logic [NBUS-1:0]   c45_mode;
  logic [NPORT-1:0]  poll_q;
  logic [31:26]      cmd_hi;
  logic [24:1]       cmd_mid;
  logic [31:0]       data_q;
  logic [20:0]       mmd_q;
  logic [NPORT-1:0]  psel_q;
  logic [CNT_W-1:0]  lim_q;

  logic              busy, fail, rsp_take;
  logic [15:0]       rsp_word;
  logic [PW-1:0]     wr_idx, lk_port;
  logic [BUS_FW-1:0] lk_bus;
  logic [PHY_FW-1:0] lk_phy;
  logic              map_hit;
  logic [31:0]       map_word;
  logic              start, port_ok, start_ok;

  assign start = reg_wr && (reg_addr == A_CMD) && !busy && reg_wdata[0];

  always_comb begin
    wr_idx = '0;
    for (int i = 0; i < NPORT; i++)
      if (psel_q[i]) wr_idx = PW'(i);
  end

  assign lk_port  = reg_wdata[2] ? wr_idx : data_q[16 +: PW];
  assign port_ok  = reg_wdata[2] ? ($countones(psel_q) == 1)
                                 : (data_q[31:16] < 16'(NPORT));
  assign start_ok = port_ok && (reg_wdata[1] == c45_mode[lk_bus]);

  mdio_port_map #(.NPORT(NPORT)) u_map (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .port   (lk_port),
    .lk_bus (lk_bus),
    .lk_phy (lk_phy),
    .rd_hit (map_hit),
    .rd_word(map_word)
  );

  mdio_cmd_seq #(.NBUS(NBUS), .CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .start_ok    (start_ok),
    .sel_bus     (lk_bus),
    .sel_phy     (lk_phy),
    .limit       (lim_q),
    .mb_req_ready(mb_req_ready),
    .mb_rsp_valid(mb_rsp_valid),
    .mb_rsp_data (mb_rsp_data),
    .mb_req_valid(mb_req_valid),
    .phy_q       (mb_phy),
    .busy        (busy),
    .fail        (fail),
    .rsp_take    (rsp_take),
    .rsp_word    (rsp_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c45_mode <= '0;
      poll_q   <= '0;
      cmd_hi   <= '0;
      cmd_mid  <= '0;
      data_q   <= '0;
      mmd_q    <= '0;
      psel_q   <= '0;
      lim_q    <= CNT_W'(DEF_LIMIT);
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          A_GCTRL: c45_mode <= reg_wdata[16 +: NBUS];
          A_POLL:  poll_q   <= reg_wdata[NPORT-1:0];
          A_LIMIT: lim_q    <= reg_wdata[CNT_W-1:0];
          default: ;
        endcase
      end
      if (reg_wr && !busy) begin
        case (reg_addr)
          A_CMD: begin
            cmd_hi  <= reg_wdata[31:26];
            cmd_mid <= reg_wdata[24:1];
          end
          A_DATA:  data_q <= reg_wdata;
          A_MMD:   mmd_q  <= reg_wdata[20:0];
          A_PSEL:  psel_q <= reg_wdata[NPORT-1:0];
          default: ;
        endcase
      end
      if (rsp_take && !cmd_mid[2]) data_q[15:0] <= rsp_word;
    end
  end

  assign poll_en  = poll_q;
  assign mb_c45   = cmd_mid[1];
  assign mb_write = cmd_mid[2];
  assign mb_dev   = cmd_mid[1] ? mmd_q[20:16] : 5'd0;
  assign mb_reg   = cmd_mid[1] ? mmd_q[15:0] : {11'd0, cmd_mid[24:20]};
  assign mb_wdata = data_q[31:16];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_GCTRL: reg_rdata[16 +: NBUS] = c45_mode;
      A_POLL:  reg_rdata[NPORT-1:0]  = poll_q;
      A_CMD:   reg_rdata = {cmd_hi, fail, cmd_mid, busy};
      A_DATA:  reg_rdata = data_q;
      A_MMD:   reg_rdata[20:0] = mmd_q;
      A_PSEL:  reg_rdata[NPORT-1:0] = psel_q;
      A_LIMIT: reg_rdata[CNT_W-1:0] = lim_q;
      default: if (map_hit) reg_rdata = map_word;
    endcase
  end

  AST_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable({cmd_hi, cmd_mid, mmd_q, psel_q, data_q[31:16]})); // R7
  AST_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((|mb_req_valid) && $past(|mb_req_valid))
      |-> $stable({mb_phy, mb_dev, mb_reg, mb_wdata, mb_c45, mb_write})); // R10
  AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (|mb_req_valid) |-> busy); // R10
  AST_WRITE_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mb_write) |=> $stable(data_q)); // R4
endmodule

// File: tb/port_mdio_engine_tb.sv
module port_mdio_engine_tb;
  localparam int CLK_P = 10;
  localparam int NP = 28;
  localparam logic [3:0] T_GCTRL = 4'd0, T_POLL = 4'd1, T_CMD = 4'd2, T_DATA = 4'd3,
                         T_MMD = 4'd4, T_PSEL = 4'd5, T_LIMIT = 4'd6, T_SEL0 = 4'd8,
                         T_PHY0 = 4'd10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NP-1:0] poll_en;
  logic [3:0]  mb_req_valid;
  logic [3:0]  mb_req_ready = '0;
  logic        mb_c45, mb_write;
  logic [4:0]  mb_phy, mb_dev;
  logic [15:0] mb_reg, mb_wdata;
  logic [3:0]  mb_rsp_valid = '0;
  logic [63:0] mb_rsp_data = '0;

  int total = 0;
  int bad = 0;
  int m_state = 0, m_cnt = 0, m_bus = 0;
  int rdy_lat = 1, rsp_lat = 2;
  logic [3:0] dead = '0;
  int req_count = 0;
  int cap_bus;
  logic cap_c45, cap_wr;
  logic [4:0] cap_phy, cap_dev;
  logic [15:0] cap_reg, cap_wd;
  int mbus[NP];
  int mphy[NP];
  logic [3:0] mode;

  port_mdio_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .poll_en(poll_en),
    .mb_req_valid(mb_req_valid), .mb_req_ready(mb_req_ready), .mb_c45(mb_c45),
    .mb_write(mb_write), .mb_phy(mb_phy), .mb_dev(mb_dev), .mb_reg(mb_reg),
    .mb_wdata(mb_wdata), .mb_rsp_valid(mb_rsp_valid), .mb_rsp_data(mb_rsp_data)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [15:0] hv(int b, logic [4:0] phy, logic [4:0] dv, logic [15:0] ra);
    int x;
    x = b * 7 + int'(phy) * 131 + int'(dv) * 977 + int'(ra) * 3;
    return 16'(x) ^ 16'h5a3c;
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      reg_read(T_CMD, v);
      if (!v[0]) break;
    end
  endtask

  task automatic program_map();
    logic [31:0] w;
    for (int k = 0; k < 2; k++) begin
      w = '0;
      for (int j = 0; j < 16; j++)
        if (k * 16 + j < NP) w |= 32'(mbus[k * 16 + j] & 3) << (2 * j);
      reg_write(T_SEL0 + 4'(k), w);
    end
    for (int k = 0; k < 5; k++) begin
      w = '0;
      for (int j = 0; j < 6; j++)
        if (k * 6 + j < NP) w |= 32'(mphy[k * 6 + j] & 31) << (5 * j);
      reg_write(T_PHY0 + 4'(k), w);
    end
    reg_write(T_GCTRL, {12'd0, mode, 16'd0});
  endtask

  function automatic logic [31:0] cmd_word(bit wr, bit c45, logic [4:0] r5);
    return {6'd0, 1'b0, r5, 5'h1f, 12'hfff, wr, c45, 1'b1};
  endfunction

  task automatic do_txn(input int port, input bit wr, input bit c45, input logic [4:0] r5,
                        input logic [4:0] dv, input logic [15:0] ra, input logic [15:0] wd);
    logic [31:0] v;
    logic [4:0] e_dev;
    logic [15:0] e_reg;
    int rc0;
    rc0 = req_count;
    e_dev = c45 ? dv : 5'd0;
    e_reg = c45 ? ra : {11'd0, r5};
    if (wr) begin
      reg_write(T_PSEL, 32'd1 << port);
      reg_write(T_DATA, {wd, 16'h1234});
    end else begin
      reg_write(T_DATA, {16'(port), 16'hbeef});
    end
    if (c45) reg_write(T_MMD, {11'd0, dv, ra});
    reg_write(T_CMD, cmd_word(wr, c45, r5));
    wait_idle();
    reg_read(T_CMD, v);
    chk("R12 fail cleared after response", 32'(v[25]), 32'd0);
    chk("R10 one request issued", 32'(req_count), 32'(rc0 + 1));
    chk("R2 resolved bus", 32'(cap_bus), 32'(mbus[port]));
    chk("R2 resolved phy", 32'(cap_phy), 32'(mphy[port]));
    chk("R6 request clause", 32'(cap_c45), 32'(c45));
    chk("R5 register field", 32'(cap_reg), 32'(e_reg));
    chk("R5 device field", 32'(cap_dev), 32'(e_dev));
    reg_read(T_DATA, v);
    if (wr) begin
      chk("R4 write direction", 32'(cap_wr), 32'd1);
      chk("R4 write data on request", 32'(cap_wd), 32'(wd));
      chk("R4 data register kept", v, {wd, 16'h1234});
    end else begin
      chk("R3 read direction", 32'(cap_wr), 32'd0);
      chk("R3 read result", 32'(v[15:0]), 32'(hv(mbus[port], 5'(mphy[port]), e_dev, e_reg)));
      chk("R3 port field kept", 32'(v[31:16]), 32'(port));
    end
  endtask

  // bus responder
  initial begin
    forever begin
      @(negedge clk);
      case (m_state)
        0: begin
          if (|mb_req_valid) begin
            for (int i = 0; i < 4; i++) if (mb_req_valid[i]) m_bus = i;
            if (!dead[m_bus]) begin
              if (m_cnt >= rdy_lat) begin
                mb_req_ready[m_bus] = 1'b1;
                cap_bus = m_bus; cap_phy = mb_phy; cap_c45 = mb_c45; cap_wr = mb_write;
                cap_dev = mb_dev; cap_reg = mb_reg; cap_wd = mb_wdata;
                req_count++;
                m_cnt = 0;
                m_state = 1;
              end else m_cnt++;
            end
          end else m_cnt = 0;
        end
        1: begin
          mb_req_ready = '0;
          if (m_cnt >= rsp_lat) begin
            mb_rsp_valid[cap_bus] = 1'b1;
            mb_rsp_data[cap_bus * 16 +: 16] = hv(cap_bus, cap_phy, cap_dev, cap_reg);
            m_state = 2;
          end else m_cnt++;
        end
        default: begin
          mb_rsp_valid = '0;
          mb_rsp_data = '0;
          m_cnt = 0;
          m_state = 0;
        end
      endcase
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R10 act=hung exp=finished");
    summary();
  end

  initial begin
    logic [31:0] v, psel_old, mmd_old;
    int rc0;
    void'($urandom(32'd20250131));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 no request valid", 32'(mb_req_valid), 32'd0);
    chk("R1 poll mask zero", 32'(poll_en), 32'd0);
    reg_read(T_GCTRL, v); chk("R1 clause mode", v, 32'd0);
    reg_read(T_CMD, v);   chk("R1 command", v, 32'd0);
    reg_read(T_DATA, v);  chk("R1 data", v, 32'd0);
    reg_read(T_PSEL, v);  chk("R1 port select", v, 32'd0);
    reg_read(T_LIMIT, v); chk("R1 timeout default", v, 32'd200);
    reg_read(T_SEL0, v);  chk("R1 bus table", v, 32'd0);
    reg_read(T_PHY0 + 4'd4, v); chk("R1 phy table", v, 32'd0);

    // R11 polling mask
    reg_write(T_POLL, 32'hffff_ffff);
    reg_read(T_POLL, v);
    chk("R11 poll readback", v, 32'h0fff_ffff);
    chk("R11 poll output", 32'(poll_en), 32'h0fff_ffff);
    reg_write(T_POLL, 32'h0000_00a5);
    chk("R11 poll output pattern", 32'(poll_en), 32'h0000_00a5);
    reg_write(T_POLL, 32'd0);

    // directed map
    for (int p = 0; p < NP; p++) begin
      mbus[p] = p % 4;
      mphy[p] = (p * 7 + 3) % 32;
    end
    mode = 4'b1010;
    program_map();
    reg_read(T_PHY0 + 4'd4, v);
    chk("R2 phy table readback", v, {2'b0, 5'(mphy[29 % NP]) & 5'd0, 5'(mphy[27]), 5'(mphy[26]),
                                     5'(mphy[25]), 5'(mphy[24])} & 32'h000f_ffff);
    do_txn(0, 1'b0, 1'b0, 5'd2, 5'd0, 16'd0, 16'd0);          // R3 R5 C22 read
    do_txn(27, 1'b0, 1'b1, 5'd0, 5'd7, 16'h2a01, 16'd0);      // R2 last port, C45 read
    do_txn(5, 1'b1, 1'b1, 5'd0, 5'd30, 16'hc001, 16'h7e55);   // R4 C45 write
    do_txn(26, 1'b1, 1'b0, 5'd17, 5'd0, 16'd0, 16'h0f0f);     // R4 C22 write

    // R6 clause mismatch
    rc0 = req_count;
    reg_write(T_DATA, {16'd0, 16'h4444});
    reg_write(T_CMD, cmd_word(1'b0, 1'b1, 5'd1));
    reg_read(T_CMD, v);
    chk("R6 mismatch fails", 32'(v[25]), 32'd1);
    chk("R6 mismatch not busy", 32'(v[0]), 32'd0);
    chk("R6 mismatch no request", 32'(req_count), 32'(rc0));
    reg_read(T_DATA, v);
    chk("R6 mismatch data kept", v, {16'd0, 16'h4444});
    do_txn(4, 1'b0, 1'b0, 5'd9, 5'd0, 16'd0, 16'd0);          // R12 clears fail

    // R8 bad targets
    rc0 = req_count;
    reg_write(T_PSEL, 32'd0);
    reg_write(T_CMD, cmd_word(1'b1, 1'b0, 5'd1));
    reg_read(T_CMD, v);
    chk("R8 empty mask fails", 32'(v[25]), 32'd1);
    do_txn(8, 1'b0, 1'b0, 5'd3, 5'd0, 16'd0, 16'd0);
    rc0 = req_count;
    reg_write(T_PSEL, 32'h0000_0011);
    reg_write(T_CMD, cmd_word(1'b1, 1'b0, 5'd1));
    reg_read(T_CMD, v);
    chk("R8 two-bit mask fails", 32'(v[25]), 32'd1);
    reg_write(T_DATA, {16'd28, 16'h5555});
    reg_write(T_CMD, cmd_word(1'b0, 1'b0, 5'd1));
    reg_read(T_CMD, v);
    chk("R8 port 28 fails", 32'(v[25]), 32'd1);
    chk("R8 no request issued", 32'(req_count), 32'(rc0));

    // R7 writes ignored while busy, R10 only mapped bus valid
    rdy_lat = 5; rsp_lat = 30;
    reg_write(T_PSEL, 32'd1 << 9);
    reg_write(T_MMD, 32'h0003_1234);
    reg_read(T_PSEL, psel_old);
    reg_read(T_MMD, mmd_old);
    reg_write(T_DATA, {16'd6, 16'hbeef});
    rc0 = req_count;
    reg_write(T_CMD, cmd_word(1'b0, 1'b0, 5'd3));
    chk("R10 valid on mapped bus only", 32'(mb_req_valid), 32'd1 << mbus[6]);
    reg_write(T_DATA, 32'hffff_0000);
    reg_write(T_MMD, 32'h001f_ffff);
    reg_write(T_PSEL, 32'd1);
    reg_write(T_CMD, cmd_word(1'b1, 1'b0, 5'd3));
    wait_idle();
    chk("R7 start while busy ignored", 32'(req_count), 32'(rc0 + 1));
    reg_read(T_PSEL, v); chk("R7 port select kept", v, psel_old);
    reg_read(T_MMD, v);  chk("R7 address kept", v, mmd_old);
    reg_read(T_CMD, v);  chk("R7 command kept", 32'(v[2]), 32'd0);
    reg_read(T_DATA, v);
    chk("R7 data port kept", 32'(v[31:16]), 32'd6);
    chk("R7 read result", 32'(v[15:0]), 32'(hv(mbus[6], 5'(mphy[6]), 5'd0, 16'd3)));
    rdy_lat = 1; rsp_lat = 2;

    // R9 timeout
    reg_write(T_LIMIT, 32'd12);
    reg_read(T_LIMIT, v); chk("R9 limit readback", v, 32'd12);
    dead[mbus[2]] = 1'b1;
    rc0 = req_count;
    reg_write(T_DATA, {16'd2, 16'h7777});
    reg_write(T_CMD, cmd_word(1'b0, 1'b0, 5'd4));
    wait_idle();
    reg_read(T_CMD, v);
    chk("R9 timeout fails", 32'(v[25]), 32'd1);
    reg_read(T_DATA, v);
    chk("R9 data unchanged", v, {16'd2, 16'h7777});
    chk("R9 no acceptance", 32'(req_count), 32'(rc0));
    chk("R9 request dropped", 32'(mb_req_valid), 32'd0);
    dead = '0;
    reg_write(T_LIMIT, 32'd200);

    // random mix
    for (int it = 0; it < 40; it++) begin
      int p;
      bit wr;
      for (int q = 0; q < NP; q++) begin
        mbus[q] = int'($urandom_range(3, 0));
        mphy[q] = int'($urandom_range(31, 0));
      end
      mode = 4'($urandom_range(15, 0));
      if (it % 8 == 0) program_map();
      else begin
        for (int q = 0; q < NP; q++) begin
          mbus[q] = q % 4;
          mphy[q] = (q * 7 + 3) % 32;
        end
        mode = 4'b1010;
        if (it % 8 == 1) program_map();
      end
      rdy_lat = int'($urandom_range(4, 0));
      rsp_lat = int'($urandom_range(6, 0));
      p = int'($urandom_range(NP - 1, 0));
      wr = bit'($urandom_range(1, 0));
      do_txn(p, wr, mode[mbus[p]], 5'($urandom_range(31, 0)), 5'($urandom_range(31, 0)),
             16'($urandom_range(65535, 0)), 16'($urandom_range(65535, 0)));
    end

    summary();
  end
endmodule